// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as eight two-digit BCD fields: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. A single-cycle `tick_i` pulse arriving at 100 Hz advances the hundredths field. Carries ripple upward through the whole calendar in the same clock, so every field is updated together. The last date of each month comes from the month and a two-digit year, and February receives 29 days in leap years.

A host sets the time by presenting a complete 64-bit image on `load_data_i` and pulsing `load_i`. All eight fields are visible together on `snap_o`. Field k occupies bits 8k+7 down to 8k of both ports. Hours can run in a 24-hour or a 12-hour format, with a meridiem flag in the 12-hour format. A stop flag in the day-of-week field freezes the count, and this flag is set after reset, so time does not advance until a load clears it.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, `snap_o` reads 64'h00_01_01_21_00_00_00_00: year 00, month 01, date 01, day-of-week 1 with the stop flag set, 24-hour mode at hour 00, and zero minutes, seconds and hundredths.
- R2: When `load_i` is high at a clock edge, the snapshot after that edge equals the masked load word. Field k occupies bits 8k+7:8k, with fields 0..7 being hundredths, seconds, minutes, hours, day-of-week, date, month and year. A tick in the same cycle is discarded.
- R3: Bits without a function always read 0, whatever was loaded: bit 7 of seconds and minutes, bit 6 of hours, bits 7:6 and 4:3 of day-of-week, bits 7:6 of date, and bits 7:5 of month.
- R4: With the stop flag clear, each tick adds one to the hundredths field, which wraps from 99 to 00 and carries into seconds. Without a tick or a load, the snapshot holds.
- R5: Seconds and minutes each wrap from 59 to 00 and carry into the next field when the field below them wraps.
- R6: In 24-hour mode (hours bit 7 = 0), hours count 00..23 in BCD, with bit 5 as the second tens bit for 20..23. The step from 23 gives 00 and advances day-of-week and date.
- R7: In 12-hour mode (hours bit 7 = 1), bits 4:0 count 12, 01, ..., 11, and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles the flag. Only 11 PM to 12 AM advances the day. The mode bit is kept.
- R8: Day-of-week (bits 2:0) counts 1..7 and returns to 1 on the day advance after 7.
- R9: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, after 28 in February of a year not divisible by 4, after 29 in February of a year divisible by 4 (00 included), and after 31 otherwise. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: While day-of-week bit 5 (the stop flag) is 1, ticks change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 100 Hz advance pulse |
| load_i | input | 1 | Write the whole register image |
| load_data_i | input | 64 | Image to load, field k at bits 8k+7:8k |
| snap_o | output | 64 | All eight fields, same layout |

## Verification
The properties place no limit on the load word. They rely only on ticks and loads being sampled at the clock edge, and on a wrap from 99 or 59 being observed from a state the counter actually holds. Calendar correctness, however, is defined only for legal BCD values within each field's range. The stimulus therefore builds every random load from a legal date and time, often placed just before a carry boundary. The one exception is a single all-ones load, which exists only to expose the always-zero bits and the stop flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned FIELD_W     = 8;
   localparam int unsigned FIELD_N     = 8;
   localparam int unsigned SNAP_W      = FIELD_W * FIELD_N;
   localparam int unsigned TIME_FIELDS = 3;

   localparam int unsigned F_HUND  = 0;
   localparam int unsigned F_SEC   = 1;
   localparam int unsigned F_MIN   = 2;
   localparam int unsigned F_HOUR  = 3;
   localparam int unsigned F_DOW   = 4;
   localparam int unsigned F_DATE  = 5;
   localparam int unsigned F_MONTH = 6;
   localparam int unsigned F_YEAR  = 7;

   localparam int unsigned HOUR_MODE_BIT = 7;
   localparam int unsigned HOUR_HI_BIT   = 5;
   localparam int unsigned DOW_STOP_BIT  = 5;

   typedef logic [FIELD_W-1:0] field_t;

   // bits that hold state in each field; the rest read as zero
   function automatic field_t keep_mask(int unsigned idx);
      case (idx)
         F_SEC, F_MIN: return 8'h7F;
         F_HOUR:       return 8'hBF;
         F_DOW:        return 8'h27;
         F_DATE:       return 8'h3F;
         F_MONTH:      return 8'h1F;
         default:      return 8'hFF;
      endcase
   endfunction

   // largest BCD value of a fixed-range field
   function automatic field_t field_ceiling(int unsigned idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_MONTH:      return 8'h12;
         default:      return 8'h99;
      endcase
   endfunction

   function automatic logic [SNAP_W-1:0] snap_mask();
      logic [SNAP_W-1:0] m;
      m = '0;
      for (int unsigned k = 0; k < FIELD_N; k++)
         m[k*FIELD_W +: FIELD_W] = keep_mask(k);
      return m;
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter int unsigned   W       = 8,
   parameter int unsigned   DIGIT_W = 4,
   parameter logic [W-1:0]  FLOOR   = '0
) (
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] ceil_i,
   output logic [W-1:0] nxt_o,
   output logic         wrap_o
);
   localparam int unsigned HI_W = W - DIGIT_W;

   if (W != 2 * DIGIT_W) begin : g_bad_width
      $error("rtc_bcd_field: W must hold exactly two BCD digits");
   end

   always_comb begin
      wrap_o = (cur_i >= ceil_i);
      if (wrap_o)
         nxt_o = FLOOR;
      else if (cur_i[DIGIT_W-1:0] >= DIGIT_W'(9))
         nxt_o = {cur_i[W-1:DIGIT_W] + HI_W'(1), DIGIT_W'(0)};
      else
         nxt_o = {cur_i[W-1:DIGIT_W], cur_i[DIGIT_W-1:0] + DIGIT_W'(1)};
   end
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] cur_i,
   output logic [W-1:0] nxt_o,
   output logic         day_o
);
   if (W != 8) begin : g_bad_width
      $error("rtc_hour_field: hour field layout needs W == 8");
   end

   always_comb begin
      nxt_o = cur_i;
      day_o = 1'b0;
      if (cur_i[7]) begin
         // 12-hour: bit 5 meridiem, bits 4:0 run 12,01..11
         if (cur_i[4:0] >= 5'h12)
            nxt_o = {2'b10, cur_i[5], 5'h01};
         else if (cur_i[4:0] == 5'h11) begin
            nxt_o = {2'b10, ~cur_i[5], 5'h12};
            day_o = cur_i[5];
         end else if (cur_i[3:0] >= 4'd9)
            nxt_o = {2'b10, cur_i[5], 5'h10};
         else
            nxt_o = {2'b10, cur_i[5], cur_i[4], cur_i[3:0] + 4'd1};
      end else begin
         if (cur_i[6:0] >= 7'h23) begin
            nxt_o = 8'h00;
            day_o = 1'b1;
         end else if (cur_i[3:0] >= 4'd9)
            nxt_o = {2'b00, cur_i[5:4] + 2'd1, 4'd0};
         else
            nxt_o = {2'b00, cur_i[5:4], cur_i[3:0] + 4'd1};
      end
   end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
   parameter int unsigned W       = 8,
   parameter bit          LEAP_EN = 1'b1
) (
   input  logic [W-1:0] month_i,
   input  logic [W-1:0] year_i,
   output logic [W-1:0] last_o
);
   logic leap;

   if (LEAP_EN) begin : g_leap
      assign leap = ((7'(year_i[7:4]) * 7'd10 + 7'(year_i[3:0])) % 7'd4) == 7'd0;
   end else begin : g_no_leap
      logic [W-1:0] year_unused;
      assign year_unused = year_i;
      assign leap = 1'b0;
   end

   always_comb begin
      case (month_i)
         8'h02:                      last_o = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
         default:                    last_o = 8'h31;
      endcase
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter bit          RST_MODE12   = 1'b0,
   parameter bit          RST_OSC_STOP = 1'b1,
   parameter int unsigned RST_DOW      = 1,
   parameter logic [7:0]  RST_YEAR     = 8'h00,
   parameter bit          LEAP_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [SNAP_W-1:0] load_data_i,
   output logic [SNAP_W-1:0] snap_o
);
   localparam field_t RST_HOUR = RST_MODE12 ? 8'h92 : 8'h00;
   localparam field_t RST_DAY  = {2'b00, RST_OSC_STOP, 2'b00, 3'(RST_DOW)};
   localparam logic [SNAP_W-1:0] RST_IMAGE =
      {RST_YEAR, 8'h01, 8'h01, RST_DAY, RST_HOUR, 8'h00, 8'h00, 8'h00};

   if (RST_DOW < 1 || RST_DOW > 7) begin : g_bad_dow
      $error("rtc_calendar: RST_DOW must be 1..7");
   end
   if (RST_YEAR[7:4] > 4'd9 || RST_YEAR[3:0] > 4'd9) begin : g_bad_year
      $error("rtc_calendar: RST_YEAR must be BCD");
   end
   if (FIELD_N != 8 || FIELD_W != 8) begin : g_bad_shape
      $error("rtc_calendar: eight 8-bit fields expected");
   end

   field_t                 regs_q [FIELD_N];
   field_t                 nxt    [FIELD_N];
   logic [FIELD_N-1:0]     step;
   logic [TIME_FIELDS-1:0] wrap_t;
   logic                   hour_day;
   logic                   date_wrap;
   logic                   month_wrap;
   logic                   year_wrap_unused;
   field_t                 last_date;

   // hundredths, seconds, minutes share one fixed-range counter shape
   for (genvar k = 0; k < TIME_FIELDS; k++) begin : g_time
      rtc_bcd_field #(.W(FIELD_W), .FLOOR(field_t'(0))) u_fld (
         .cur_i  (regs_q[k]),
         .ceil_i (field_ceiling(k)),
         .nxt_o  (nxt[k]),
         .wrap_o (wrap_t[k])
      );
   end

   rtc_hour_field #(.W(FIELD_W)) u_hour (
      .cur_i (regs_q[F_HOUR]),
      .nxt_o (nxt[F_HOUR]),
      .day_o (hour_day)
   );

   always_comb begin
      nxt[F_DOW] = {regs_q[F_DOW][7:3],
                    (regs_q[F_DOW][2:0] >= 3'd7 || regs_q[F_DOW][2:0] == 3'd0)
                       ? 3'd1 : regs_q[F_DOW][2:0] + 3'd1};
   end

   rtc_month_len #(.W(FIELD_W), .LEAP_EN(LEAP_EN)) u_mlen (
      .month_i (regs_q[F_MONTH]),
      .year_i  (regs_q[F_YEAR]),
      .last_o  (last_date)
   );

   rtc_bcd_field #(.W(FIELD_W), .FLOOR(field_t'(1))) u_date (
      .cur_i  (regs_q[F_DATE]),
      .ceil_i (last_date),
      .nxt_o  (nxt[F_DATE]),
      .wrap_o (date_wrap)
   );

   rtc_bcd_field #(.W(FIELD_W), .FLOOR(field_t'(1))) u_month (
      .cur_i  (regs_q[F_MONTH]),
      .ceil_i (field_ceiling(F_MONTH)),
      .nxt_o  (nxt[F_MONTH]),
      .wrap_o (month_wrap)
   );

   rtc_bcd_field #(.W(FIELD_W), .FLOOR(field_t'(0))) u_year (
      .cur_i  (regs_q[F_YEAR]),
      .ceil_i (field_ceiling(F_YEAR)),
      .nxt_o  (nxt[F_YEAR]),
      .wrap_o (year_wrap_unused)
   );

   // carry chain: each field steps when every field below it wraps
   always_comb begin
      step[F_HUND]  = tick_i & ~regs_q[F_DOW][DOW_STOP_BIT];
      step[F_SEC]   = step[F_HUND] & wrap_t[F_HUND];
      step[F_MIN]   = step[F_SEC]  & wrap_t[F_SEC];
      step[F_HOUR]  = step[F_MIN]  & wrap_t[F_MIN];
      step[F_DOW]   = step[F_HOUR] & hour_day;
      step[F_DATE]  = step[F_DOW];
      step[F_MONTH] = step[F_DATE] & date_wrap;
      step[F_YEAR]  = step[F_MONTH] & month_wrap;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < FIELD_N; k++)
            regs_q[k] <= RST_IMAGE[k*FIELD_W +: FIELD_W];
      end else if (load_i) begin
         for (int k = 0; k < FIELD_N; k++)
            regs_q[k] <= load_data_i[k*FIELD_W +: FIELD_W] & keep_mask(k);
      end else begin
         for (int k = 0; k < FIELD_N; k++)
            if (step[k]) regs_q[k] <= nxt[k];
      end
   end

   for (genvar k = 0; k < FIELD_N; k++) begin : g_snap
      assign snap_o[k*FIELD_W +: FIELD_W] = regs_q[k];
   end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
   import rtc_cal_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              load_i,
   input logic [SNAP_W-1:0] load_data_i,
   input logic [SNAP_W-1:0] snap_o
);
   localparam logic [SNAP_W-1:0] KEEP = snap_mask();
   localparam int unsigned STOP_POS = F_DOW * FIELD_W + DOW_STOP_BIT;
   localparam int unsigned MODE_POS = F_HOUR * FIELD_W + HOUR_MODE_BIT;

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> snap_o == ($past(load_data_i) & KEEP));

   p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_o & ~KEEP) == '0);

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(snap_o));

   p_hund_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && !snap_o[STOP_POS]
       && snap_o[F_HUND*FIELD_W +: FIELD_W] == 8'h99)
      |=> snap_o[F_HUND*FIELD_W +: FIELD_W] == 8'h00);

   p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && !snap_o[STOP_POS]
       && snap_o[F_HUND*FIELD_W +: FIELD_W] == 8'h99
       && snap_o[F_SEC*FIELD_W +: FIELD_W] == 8'h59)
      |=> snap_o[F_SEC*FIELD_W +: FIELD_W] == 8'h00);

   p_mode_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> snap_o[MODE_POS] == $past(snap_o[MODE_POS]));

   p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_o[STOP_POS] && !load_i) |=> $stable(snap_o));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        load_i = 1'b0;
   logic [63:0] load_data_i = '0;
   logic [63:0] snap_o;

   int checks = 0;
   int errors = 0;

   int m_hs, m_s, m_mi, m_h, m_dow, m_date, m_mon, m_yr;
   bit m_12, m_stop;

   rtc_calendar u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
      .load_data_i(load_data_i), .snap_o(snap_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] b2(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(int mon, int yr);
      case (mon)
         2:           return (yr % 4 == 0) ? 29 : 28;
         4, 6, 9, 11: return 30;
         default:     return 31;
      endcase
   endfunction

   function automatic logic [63:0] m_image();
      logic [7:0] hr;
      int h12;
      h12 = (m_h % 12 == 0) ? 12 : m_h % 12;
      hr = m_12 ? (8'h80 | (m_h >= 12 ? 8'h20 : 8'h00) | b2(h12)) : b2(m_h);
      return {b2(m_yr), b2(m_mon), b2(m_date), {2'b00, m_stop, 2'b00, 3'(m_dow)},
              hr, b2(m_mi), b2(m_s), b2(m_hs)};
   endfunction

   task automatic m_tick();
      if (m_stop) return;
      m_hs++;  if (m_hs < 100) return;  m_hs = 0;
      m_s++;   if (m_s < 60) return;    m_s = 0;
      m_mi++;  if (m_mi < 60) return;   m_mi = 0;
      m_h++;   if (m_h < 24) return;    m_h = 0;
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      m_date++; if (m_date <= dim(m_mon, m_yr)) return; m_date = 1;
      m_mon++;  if (m_mon <= 12) return; m_mon = 1;
      m_yr = (m_yr + 1) % 100;
   endtask

   task automatic check(logic [63:0] act, logic [63:0] exp, string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(bit tk, bit ld, logic [63:0] d);
      tick_i = tk; load_i = ld; load_data_i = d;
      @(posedge clk);
      @(negedge clk);
      tick_i = 1'b0; load_i = 1'b0;
   endtask

   task automatic step_model(bit tk, bit ld, string req);
      drive(tk, ld, m_image());
      if (!ld && tk) m_tick();
      check(snap_o, m_image(), req);
   endtask

   task automatic setm(int yr, int mon, int date, int dow, int h, int mi, int s,
                       int hs, bit m12);
      m_yr = yr; m_mon = mon; m_date = date; m_dow = dow; m_h = h;
      m_mi = mi; m_s = s; m_hs = hs; m_12 = m12; m_stop = 1'b0;
   endtask

   task automatic midnight_case(int yr, int mon, int date, int eyr, int emon, int edate);
      setm(yr, mon, date, 2, 23, 59, 59, 99, 1'b0);
      step_model(1'b0, 1'b1, "R9");
      step_model(1'b1, 1'b0, "R9");
      check({40'd0, snap_o[63:40]}, {40'd0, b2(eyr), b2(emon), b2(edate)}, "R9");
   endtask

   task automatic rand_state();
      m_yr = $urandom_range(99, 0);   m_mon = $urandom_range(12, 1);
      m_date = $urandom_range(dim(m_mon, m_yr), 1);
      m_dow = $urandom_range(7, 1);   m_h = $urandom_range(23, 0);
      m_mi = $urandom_range(59, 0);   m_s = $urandom_range(59, 0);
      m_hs = $urandom_range(99, 0);   m_12 = 1'($urandom_range(1, 0));
      m_stop = ($urandom_range(7, 0) == 0);
      case ($urandom_range(3, 0))
         0: begin m_hs = 90; m_s = 59; m_mi = 59; end
         1: begin
            m_hs = 95; m_s = 59; m_mi = 59;
            m_h = $urandom_range(1, 0) ? 23 : 11;
            if ($urandom_range(1, 0) == 1) m_mon = 12;
            m_date = dim(m_mon, m_yr);
         end
         default: ;
      endcase
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset image
      check(snap_o, 64'h00_01_01_21_00_00_00_00, "R1");
      setm(0, 1, 1, 1, 0, 0, 0, 0, 1'b0); m_stop = 1'b1;
      // R10 stopped after reset
      for (int i = 0; i < 5; i++) step_model(1'b1, 1'b0, "R10");
      check(snap_o, 64'h00_01_01_21_00_00_00_00, "R10");

      // R3 unused bits read zero; tick in same cycle ignored
      drive(1'b1, 1'b1, '1);
      check(snap_o, 64'hFF_1F_3F_27_BF_7F_7F_FF, "R3");
      drive(1'b1, 1'b0, '0);
      check(snap_o, 64'hFF_1F_3F_27_BF_7F_7F_FF, "R10");

      // R2 load overrides tick
      setm(24, 2, 28, 3, 9, 30, 15, 42, 1'b0);
      step_model(1'b1, 1'b1, "R2");
      check(snap_o, 64'h24_02_28_03_09_30_15_42, "R2");

      // R4 hundredths wrap and idle hold
      setm(24, 2, 28, 3, 9, 30, 15, 98, 1'b0);
      step_model(1'b0, 1'b1, "R4");
      step_model(1'b1, 1'b0, "R4");
      step_model(1'b1, 1'b0, "R4");
      check({56'd0, snap_o[15:0]} , {48'd0, 16'h16_00}, "R4");
      for (int i = 0; i < 3; i++) step_model(1'b0, 1'b0, "R4");

      // R5 R6 midnight roll in 24-hour mode
      setm(23, 6, 14, 4, 23, 59, 59, 99, 1'b0);
      step_model(1'b0, 1'b1, "R5");
      step_model(1'b1, 1'b0, "R6");
      check(snap_o, 64'h23_06_15_05_00_00_00_00, "R6");
      setm(23, 6, 14, 4, 19, 59, 59, 99, 1'b0);
      step_model(1'b0, 1'b1, "R6");
      step_model(1'b1, 1'b0, "R5");
      check({56'd0, snap_o[31:24]}, 64'h20, "R6");

      // R7 12-hour transitions
      setm(23, 6, 14, 4, 11, 59, 59, 99, 1'b1);
      step_model(1'b0, 1'b1, "R7");
      step_model(1'b1, 1'b0, "R7");
      check({56'd0, snap_o[31:24]}, 64'hB2, "R7");
      check({56'd0, snap_o[47:40]}, 64'h14, "R7");
      setm(23, 6, 14, 4, 23, 59, 59, 99, 1'b1);
      step_model(1'b0, 1'b1, "R7");
      step_model(1'b1, 1'b0, "R7");
      check({48'd0, snap_o[47:40], snap_o[31:24]}, 64'h15_92, "R7");
      setm(23, 6, 14, 4, 12, 59, 59, 99, 1'b1);
      step_model(1'b0, 1'b1, "R7");
      step_model(1'b1, 1'b0, "R7");
      check({56'd0, snap_o[31:24]}, 64'hA1, "R7");
      setm(23, 6, 14, 4, 0, 59, 59, 99, 1'b1);
      step_model(1'b0, 1'b1, "R7");
      step_model(1'b1, 1'b0, "R7");
      check({56'd0, snap_o[31:24]}, 64'h81, "R7");

      // R8 day-of-week wrap
      setm(23, 6, 14, 7, 23, 59, 59, 99, 1'b0);
      step_model(1'b0, 1'b1, "R8");
      step_model(1'b1, 1'b0, "R8");
      check({56'd0, snap_o[39:32]}, 64'h01, "R8");

      // R9 month lengths and year roll
      midnight_case(23, 2, 28, 23, 3, 1);
      midnight_case(24, 2, 28, 24, 2, 29);
      midnight_case(24, 2, 29, 24, 3, 1);
      midnight_case(0, 2, 28, 0, 2, 29);
      midnight_case(23, 4, 30, 23, 5, 1);
      midnight_case(23, 11, 30, 23, 12, 1);
      midnight_case(23, 1, 31, 23, 2, 1);
      midnight_case(99, 12, 31, 0, 1, 1);

      // R10 stop flag set by load freezes time
      setm(23, 6, 14, 4, 23, 59, 59, 99, 1'b0); m_stop = 1'b1;
      step_model(1'b0, 1'b1, "R10");
      for (int i = 0; i < 4; i++) step_model(1'b1, 1'b0, "R10");
      check(snap_o[7:0] == 8'h99 ? 64'd1 : 64'd0, 64'd1, "R10");

      // random legal states with mixed ticks
      for (int it = 0; it < 400; it++) begin
         rand_state();
         step_model(1'($urandom_range(1, 0)), 1'b1, "R2");
         for (int c = 0; c < int'($urandom_range(60, 1)); c++)
            step_model(($urandom_range(3, 0) != 0), 1'b0, "R4");
      end

      finish_run();
   end
endmodule